// File: doc/BRIEF.md
# Secure Execution Mode Controller and Region Permission Checker

This block sits beside the load/store and fetch path of a secure processor core. It keeps track of which execution mode the core is in: standard, secure, or suspended secure. For every memory access it looks up the address in a small table of programmable regions and rules on the access. An access is either allowed or faulted. An allowed access into a protected region is also tagged so that the memory path runs integrity checking and, for private regions, encryption on it.

Mode changes follow a fixed protocol. A start-up entry request launches a hash of the protected kernel code, and secure execution begins only after that hash reports completion. Secure code may suspend itself so that untrusted helper code can run. That helper code can reach only unprotected memory, and it can hand control back only by naming the one registered resume address. An integrity abort from the memory path, or any faulted access, drops the core straight back to standard mode with no attempt at recovery.

Top module: `secmode_guard`

## Requirements
- R1: The mode output uses 2'b00 for standard, 2'b01 for secure and 2'b10 for suspended. It never shows 2'b11. After reset the mode is standard, and hash_start and resp_valid are low.
- R2: Region i covers addresses from base i to limit i, with both ends included. Its 3-bit kind code is 0 for unprotected, 1 for static verified, 2 for static verified plus encrypted, 3 for dynamic verified and 4 for dynamic verified plus encrypted. When regions overlap, the lowest index wins. An address in no region, or a region with an unknown code, is treated as unprotected.
- R3: An allowed access to a verified kind asserts resp_verify. An allowed access to an encrypted kind asserts both resp_verify and resp_encrypt. An allowed unprotected access asserts neither.
- R4: A write to a static kind (code 1 or 2) faults in every mode, and a faulted response asserts no protection attribute.
- R5: Accesses to protected kinds (codes 1 to 4) are allowed only in secure mode and fault in standard and suspended modes. Unprotected accesses are allowed in every mode.
- R6: Each cycle with acc_valid high produces exactly one response on the next cycle. In that response exactly one of resp_allow and resp_fault is high. With no response, every response output is low.
- R7: A start-up entry request in standard mode raises hash_start for one cycle, starting on the cycle after the request. The mode stays standard until hash_done arrives. A hash_done with no entry pending has no effect.
- R8: A suspend request moves secure mode to suspended mode. In standard mode the request is ignored.
- R9: A resume request in suspended mode enters secure mode only when resume_target equals resume_addr. Any other target leaves the mode suspended.
- R10: A faulted access or an integrity abort forces standard mode on the same clock edge that registers the fault response. It also cancels any pending entry.
- R11: An instruction fetch is judged as a read whatever the state of acc_write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| req_enter | input | 1 | Start-up request to enter secure mode |
| hash_done | input | 1 | Kernel hash has finished |
| req_suspend | input | 1 | Request to suspend secure processing |
| req_resume | input | 1 | Request to resume secure processing |
| resume_target | input | ADDR_W | Address the resume request jumps to |
| integ_abort | input | 1 | Integrity violation reported by the memory path |
| resume_addr | input | ADDR_W | Registered resume entry address |
| rgn_base | input | N_RGN*ADDR_W | Region base addresses, region i at bits i*ADDR_W |
| rgn_limit | input | N_RGN*ADDR_W | Region limit addresses, both ends included |
| rgn_kind | input | N_RGN*3 | Region kind codes, region i at bits i*3 |
| mode | output | 2 | Current execution mode |
| hash_start | output | 1 | One-cycle pulse that starts the kernel hash |
| resp_valid | output | 1 | Response for the access of the previous cycle |
| resp_allow | output | 1 | Access allowed |
| resp_fault | output | 1 | Access refused |
| resp_verify | output | 1 | Access needs integrity checking |
| resp_encrypt | output | 1 | Access needs encryption |

## Verification
Accesses are driven back to back across every region kind. Reads and writes separate the read-only kinds from the writable ones. Fetches that carry a stray write flag show that fetches are judged as reads. Addresses at a region's first and last byte, one byte below it, inside an overlap and outside every region test the inclusive bounds, the lowest-index priority and the unprotected default. The same addresses are repeated in standard, secure and suspended mode, which separates mode gating from region decoding. The mode sequences cover entry with and without a pending hash, suspend from the wrong mode, resume to the wrong and to the right target, and both kinds of forced return to standard mode.

// File: rtl/secmode_pkg.sv
package secmode_pkg;

   localparam int KIND_W = 3;

   typedef enum logic [1:0] {
      MODE_STD = 2'b00,
      MODE_SEC = 2'b01,
      MODE_SUS = 2'b10
   } sec_mode_e;

   typedef enum logic [KIND_W-1:0] {
      RK_OPEN   = 3'd0,
      RK_RO_VER = 3'd1,
      RK_RO_ENC = 3'd2,
      RK_RW_VER = 3'd3,
      RK_RW_ENC = 3'd4
   } rgn_kind_e;

   typedef struct packed {
      logic allow;
      logic fault;
      logic verify;
      logic encrypt;
   } verdict_t;

   // Codes above the last defined kind fall back to unprotected
   function automatic rgn_kind_e kind_sanitize(logic [KIND_W-1:0] raw);
      if (raw > KIND_W'(RK_RW_ENC)) return RK_OPEN;
      return rgn_kind_e'(raw);
   endfunction

endpackage

// File: rtl/secmode_rgn_match.sv
module secmode_rgn_match
   import secmode_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int N_RGN  = 4
) (
   input  logic [ADDR_W-1:0]       addr,
   input  logic [N_RGN*ADDR_W-1:0] base,
   input  logic [N_RGN*ADDR_W-1:0] limit,
   input  logic [N_RGN*KIND_W-1:0] kinds,
   output rgn_kind_e               hit_kind
);

   logic [N_RGN-1:0]  hit;
   logic [KIND_W-1:0] kind_a [N_RGN];

   for (genvar i = 0; i < N_RGN; i++) begin : g_cmp
      assign hit[i]    = (addr >= base[i*ADDR_W +: ADDR_W]) &&
                         (addr <= limit[i*ADDR_W +: ADDR_W]);
      assign kind_a[i] = kinds[i*KIND_W +: KIND_W];
   end

   // Scan from the top so the lowest index hit is the last to write
   always_comb begin
      hit_kind = RK_OPEN;
      for (int i = N_RGN - 1; i >= 0; i--) begin
         if (hit[i]) hit_kind = kind_sanitize(kind_a[i]);
      end
   end

endmodule

// File: rtl/secmode_policy.sv
module secmode_policy
   import secmode_pkg::*;
(
   input  sec_mode_e mode,
   input  rgn_kind_e kind,
   input  logic      is_write,
   input  logic      is_fetch,
   output verdict_t  verdict
);

   logic eff_write;
   logic prot;
   logic ro;
   logic enc;

   assign eff_write = is_write && !is_fetch;
   assign prot      = (kind != RK_OPEN);
   assign ro        = (kind == RK_RO_VER) || (kind == RK_RO_ENC);
   assign enc       = (kind == RK_RO_ENC) || (kind == RK_RW_ENC);

   always_comb begin
      verdict = '0;
      if (ro && eff_write) begin
         verdict.fault = 1'b1;
      end else if (prot && mode != MODE_SEC) begin
         verdict.fault = 1'b1;
      end else begin
         verdict.allow   = 1'b1;
         verdict.verify  = prot;
         verdict.encrypt = enc;
      end
   end

endmodule

// File: rtl/secmode_fsm.sv
module secmode_fsm
   import secmode_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_enter,
   input  logic      hash_done,
   input  logic      req_suspend,
   input  logic      req_resume,
   input  logic      resume_hit,
   input  logic      kill,
   output sec_mode_e mode_q,
   output logic      hash_start
);

   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= MODE_STD;
         pend_q     <= 1'b0;
         hash_start <= 1'b0;
      end else begin
         hash_start <= 1'b0;
         if (kill) begin
            mode_q <= MODE_STD;
            pend_q <= 1'b0;
         end else begin
            case (mode_q)
               MODE_STD: begin
                  if (pend_q && hash_done) begin
                     mode_q <= MODE_SEC;
                     pend_q <= 1'b0;
                  end else if (req_enter && !pend_q) begin
                     pend_q     <= 1'b1;
                     hash_start <= 1'b1;
                  end
               end
               MODE_SEC: if (req_suspend) mode_q <= MODE_SUS;
               MODE_SUS: if (req_resume && resume_hit) mode_q <= MODE_SEC;
               default:  mode_q <= MODE_STD;
            endcase
         end
      end
   end

   // R1
   mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q != 2'b11);

   // R7
   hash_in_std_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hash_start |-> mode_q == MODE_STD);

   // R7
   entry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_STD && !(pend_q && hash_done)) |=> mode_q != MODE_SEC);

   // R9
   resume_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_SUS && !(req_resume && resume_hit)) |=> mode_q != MODE_SEC);

   // R10
   kill_to_std_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> mode_q == MODE_STD);

endmodule

// File: rtl/secmode_guard.sv
module secmode_guard
   import secmode_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int N_RGN  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     acc_valid,
   input  logic [ADDR_W-1:0]        acc_addr,
   input  logic                     acc_write,
   input  logic                     acc_fetch,
   input  logic                     req_enter,
   input  logic                     hash_done,
   input  logic                     req_suspend,
   input  logic                     req_resume,
   input  logic [ADDR_W-1:0]        resume_target,
   input  logic                     integ_abort,
   input  logic [ADDR_W-1:0]        resume_addr,
   input  logic [N_RGN*ADDR_W-1:0]  rgn_base,
   input  logic [N_RGN*ADDR_W-1:0]  rgn_limit,
   input  logic [N_RGN*KIND_W-1:0]  rgn_kind,
   output logic [1:0]               mode,
   output logic                     hash_start,
   output logic                     resp_valid,
   output logic                     resp_allow,
   output logic                     resp_fault,
   output logic                     resp_verify,
   output logic                     resp_encrypt
);

   if (ADDR_W < 4 || ADDR_W > 64) begin : g_bad_addr_w
      $error("secmode_guard: ADDR_W must lie in 4..64");
   end
   if (N_RGN < 1 || N_RGN > 64) begin : g_bad_n_rgn
      $error("secmode_guard: N_RGN must lie in 1..64");
   end

   rgn_kind_e hit_kind;
   verdict_t  verdict;
   sec_mode_e mode_q;
   logic      kill;
   logic      resume_hit;

   secmode_rgn_match #(.ADDR_W(ADDR_W), .N_RGN(N_RGN)) u_match (
      .addr     (acc_addr),
      .base     (rgn_base),
      .limit    (rgn_limit),
      .kinds    (rgn_kind),
      .hit_kind (hit_kind)
   );

   secmode_policy u_policy (
      .mode     (mode_q),
      .kind     (hit_kind),
      .is_write (acc_write),
      .is_fetch (acc_fetch),
      .verdict  (verdict)
   );

   assign resume_hit = (resume_target == resume_addr);
   assign kill       = integ_abort || (acc_valid && verdict.fault);

   secmode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_enter   (req_enter),
      .hash_done   (hash_done),
      .req_suspend (req_suspend),
      .req_resume  (req_resume),
      .resume_hit  (resume_hit),
      .kill        (kill),
      .mode_q      (mode_q),
      .hash_start  (hash_start)
   );

   assign mode = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid   <= 1'b0;
         resp_allow   <= 1'b0;
         resp_fault   <= 1'b0;
         resp_verify  <= 1'b0;
         resp_encrypt <= 1'b0;
      end else begin
         resp_valid   <= acc_valid;
         resp_allow   <= acc_valid && verdict.allow;
         resp_fault   <= acc_valid && verdict.fault;
         resp_verify  <= acc_valid && verdict.verify;
         resp_encrypt <= acc_valid && verdict.encrypt;
      end
   end

   // R6
   resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> resp_valid);

   // R6
   one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> $countones({resp_allow, resp_fault}) == 1);

   // R6
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_valid |-> !(resp_allow || resp_fault || resp_verify || resp_encrypt));

   // R3
   enc_has_ver_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_encrypt |-> resp_verify);

   // R4
   fault_bare_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_fault |-> !(resp_verify || resp_encrypt));

   // R10
   fault_std_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_fault |-> mode == 2'b00);

endmodule

// File: tb/secmode_guard_test.sv
`timescale 1ns/1ps
module secmode_guard_test;

   localparam int AW = 16;
   localparam int NR = 4;
   localparam logic [3:0] V_OPEN = 4'b1000; // {allow,fault,verify,encrypt}
   localparam logic [3:0] V_VER  = 4'b1010;
   localparam logic [3:0] V_ENC  = 4'b1011;
   localparam logic [3:0] V_FLT  = 4'b0100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 0, acc_write = 0, acc_fetch = 0;
   logic [AW-1:0] acc_addr = '0;
   logic req_enter = 0, hash_done = 0, req_suspend = 0, req_resume = 0, integ_abort = 0;
   logic [AW-1:0] resume_target = '0;
   logic [AW-1:0] resume_addr = 16'h0400;
   logic [NR*AW-1:0] rgn_base  = {16'h3800, 16'h3000, 16'h2000, 16'h1000};
   logic [NR*AW-1:0] rgn_limit = {16'h4FFF, 16'h3FFF, 16'h2FFF, 16'h1FFF};
   logic [NR*3-1:0]  rgn_kind  = {3'd4, 3'd3, 3'd2, 3'd1};
   logic [1:0] mode;
   logic hash_start, resp_valid, resp_allow, resp_fault, resp_verify, resp_encrypt;

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   logic [3:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   secmode_guard #(.ADDR_W(AW), .N_RGN(NR)) uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_write(acc_write), .acc_fetch(acc_fetch), .req_enter(req_enter),
      .hash_done(hash_done), .req_suspend(req_suspend), .req_resume(req_resume),
      .resume_target(resume_target), .integ_abort(integ_abort),
      .resume_addr(resume_addr), .rgn_base(rgn_base), .rgn_limit(rgn_limit),
      .rgn_kind(rgn_kind), .mode(mode), .hash_start(hash_start),
      .resp_valid(resp_valid), .resp_allow(resp_allow), .resp_fault(resp_fault),
      .resp_verify(resp_verify), .resp_encrypt(resp_encrypt)
   );

   task automatic check(input bit ok, input string what, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", what, got, exp);
      end
   endtask

   task automatic chk_mode(input logic [1:0] exp, input string what);
      check(mode === exp, what, {6'd0, mode}, {6'd0, exp});
   endtask

   // Monitor: pops the scoreboard on every response
   always @(negedge clk) begin
      if (rst_n && resp_valid) begin
         logic [3:0] got;
         got = {resp_allow, resp_fault, resp_verify, resp_encrypt};
         if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected response", {4'd0, got}, 8'd0);
         end else begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(got === e, t, {4'd0, got}, {4'd0, e});
         end
      end
   end

   // Driver: called at a falling edge, returns at the falling edge that shows the result
   task automatic access(input logic [AW-1:0] a, input bit wr, input bit fe,
                         input logic [3:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      acc_addr = a; acc_write = wr; acc_fetch = fe; acc_valid = 1'b1;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; acc_fetch = 1'b0;
   endtask

   task automatic enter_secure();
      req_enter = 1'b1;
      @(negedge clk);
      req_enter = 1'b0;
      check(hash_start === 1'b1, "R7 hash_start pulse", {7'd0, hash_start}, 8'd1);
      chk_mode(2'b00, "R7 still standard while hashing");
      @(negedge clk);
      check(hash_start === 1'b0, "R7 hash_start one cycle", {7'd0, hash_start}, 8'd0);
      chk_mode(2'b00, "R7 waits for hash_done");
      hash_done = 1'b1;
      @(negedge clk);
      hash_done = 1'b0;
      chk_mode(2'b01, "R7 secure after hash_done");
   endtask

   task automatic pulse_suspend();
      req_suspend = 1'b1;
      @(negedge clk);
      req_suspend = 1'b0;
   endtask

   task automatic pulse_resume(input logic [AW-1:0] tgt);
      resume_target = tgt; req_resume = 1'b1;
      @(negedge clk);
      req_resume = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk_mode(2'b00, "R1 reset mode");
      check(resp_valid === 1'b0, "R1 reset resp_valid", {7'd0, resp_valid}, 8'd0);
      check(hash_start === 1'b0, "R1 reset hash_start", {7'd0, hash_start}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // Standard mode
      access(16'h8000, 0, 0, V_OPEN, "R5 open read in standard");
      hash_done = 1'b1;
      @(negedge clk);
      hash_done = 1'b0;
      @(negedge clk);
      chk_mode(2'b00, "R7 stray hash_done ignored");
      pulse_suspend();
      chk_mode(2'b00, "R8 suspend ignored in standard");
      access(16'h1000, 0, 0, V_FLT, "R5 protected read in standard");
      chk_mode(2'b00, "R10 standard after fault");

      // Secure mode, back-to-back accesses
      enter_secure();
      access(16'h1000, 0, 0, V_VER,  "R3 static verified read");
      access(16'h1FFF, 0, 0, V_VER,  "R2 limit inclusive");
      access(16'h0FFF, 0, 0, V_OPEN, "R2 below base is unprotected");
      access(16'h2000, 0, 0, V_ENC,  "R3 static encrypted read");
      access(16'h3100, 1, 0, V_VER,  "R3 dynamic verified write");
      access(16'h3900, 1, 0, V_VER,  "R2 overlap lowest index wins");
      access(16'h4800, 0, 0, V_ENC,  "R3 dynamic encrypted read");
      access(16'h2800, 1, 1, V_ENC,  "R11 fetch with write flag");
      chk_mode(2'b01, "R11 no fault from fetch");
      access(16'h8000, 1, 0, V_OPEN, "R2 outside every region");
      access(16'h2004, 1, 0, V_FLT,  "R4 write to static in secure");
      chk_mode(2'b00, "R10 fault forces standard");
      @(negedge clk);
      check(resp_valid === 1'b0, "R6 no response when idle", {7'd0, resp_valid}, 8'd0);

      // Suspended mode
      enter_secure();
      pulse_suspend();
      chk_mode(2'b10, "R8 suspend from secure");
      access(16'h8000, 0, 0, V_OPEN, "R5 open read in suspended");
      chk_mode(2'b10, "R5 suspended kept after open access");
      pulse_resume(16'h0404);
      chk_mode(2'b10, "R9 wrong resume target refused");
      access(16'h3000, 0, 0, V_FLT, "R5 protected read in suspended");
      chk_mode(2'b00, "R10 suspended fault forces standard");

      enter_secure();
      pulse_suspend();
      pulse_resume(16'h0400);
      chk_mode(2'b01, "R9 resume at registered address");
      access(16'h3000, 1, 0, V_VER, "R3 write after resume");
      integ_abort = 1'b1;
      @(negedge clk);
      integ_abort = 1'b0;
      chk_mode(2'b00, "R10 abort forces standard");
      access(16'h1000, 1, 0, V_FLT, "R4 static write in standard");

      repeat (2) @(negedge clk);
      check(exp_q.size() == 0, "R6 every access answered", 8'(exp_q.size()), 8'd0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule